// File: doc/BRIEF.md
# Byte ALU with Pair Widening

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it takes the working register W, one operand byte (either a file-register byte or an immediate literal) and a decoded operation code. It returns the result byte, a destination choice (W or the addressed file register), a write qualifier, and a skip request for the conditional increment and decrement forms. The zero, carry and digit-carry flags and the multiply high byte are held inside the block. They are updated on the clock edge at which the commit strobe `wr_en_i` is high. The carry used by the carry-in operations and rotates is always the held carry flag.

When an increment, decrement, add or subtract writes back to one of a fixed set of low-half pointer registers, the operation widens to 16 bits. The register just below the target address supplies the high byte, which the caller reads through `fr_hi_i`. The block returns the new high byte on `result_hi_o` and raises `pair_wr_o`, so that the caller stores it at that lower address. The register file, instruction fetch and program counter belong to the surrounding core.

Top module: `byte_exec_unit`

## Requirements
- R1: The opcode values on `op_i` are those of `bxu_op_e` in the package. `to_file_i`=0 selects W (`dest_file_o`=0) and 1 selects the file register. Literal operations (`lit_sel_i`=1) and both multiplies always target W, and `OP_MOVW` always targets the file register. `OP_CMP` and `OP_TEST` drive `write_o`=0, while every other defined operation drives `write_o`=1.
- R2: `OP_ADD` and `OP_ADDC` produce W + operand (+ held carry for `OP_ADDC`). Carry is set on unsigned 8-bit overflow, digit carry is the carry out of bit 3, and zero is set when the result byte is 0.
- R3: `OP_SUB` and `OP_SUBC` produce operand − W. `OP_SUBC` also subtracts a borrow equal to the inverse of the held carry. Carry is the inverse of the 8-bit borrow and digit carry is the inverse of the low-nibble borrow. Zero is set when W equals the value subtracted. `OP_CMP` updates the flags exactly as `OP_SUB` does but writes nothing.
- R4: `OP_AND`, `OP_OR`, `OP_XOR` (each with W), `OP_NOT`, `OP_INC`, `OP_DEC`, `OP_CLR` and `OP_TEST` update only the zero flag. The same holds for `OP_MOV` of a file register into W. `OP_MOV` to a file register, `OP_MOV` of a literal and `OP_MOVW` (W into a file register) change no flags.
- R5: `OP_RL` shifts the operand left, with the held carry entering bit 0 and bit 7 going to carry. `OP_RR` shifts it right, with the held carry entering bit 7 and bit 0 going to carry. Zero and digit carry are unchanged.
- R6: `OP_SWAP` exchanges the two nibbles of the operand and changes no flag.
- R7: `OP_MULU` and `OP_MULS` form the unsigned or signed 16-bit product of W and the operand. The low byte is the result and the high byte is loaded into `mulh_o` on commit. No flag changes.
- R8: The operation widens to 16 bits when it is `OP_INC`, `OP_DEC`, `OP_ADD`, `OP_ADDC`, `OP_SUB` or `OP_SUBC`, the destination is the file register, no literal is selected, and the address is 0x05, 0x07, 0x09, 0x0D or 0x11. In that case the 16-bit value is {`fr_hi_i`, `fr_i`}. `result_o`/`result_hi_o` carry its new low/high byte and `pair_wr_o`=1. Otherwise `pair_wr_o`=0.
- R9: In 16-bit mode, carry and digit carry come from the low-byte operation alone, and zero comes from the new low byte.
- R10: `OP_INCSZ`/`OP_DECSZ` and `OP_INCSNZ`/`OP_DECSNZ` write operand ± 1 and change no flag. `skip_o` is high while `wr_en_i` is high and the result is zero (SZ forms) or non-zero (SNZ forms).
- R11: The flags and `mulh_o` are 0 after reset and change only on a clock edge with `wr_en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Decoded operation code |
| lit_sel_i | input | 1 | Use `lit_i` as the operand instead of `fr_i` |
| to_file_i | input | 1 | Direction: 0 = W, 1 = file register |
| wr_en_i | input | 1 | Commit strobe for flags and multiply high byte |
| w_i | input | 8 | Working register W |
| fr_addr_i | input | ADDR_W | File-register address |
| fr_i | input | 8 | File-register byte at `fr_addr_i` |
| fr_hi_i | input | 8 | File-register byte at `fr_addr_i` − 1 |
| lit_i | input | 8 | Immediate literal |
| result_o | output | 8 | Result byte (low byte in pair mode) |
| result_hi_o | output | 8 | New high byte in pair mode |
| dest_file_o | output | 1 | Destination: 0 = W, 1 = file register |
| write_o | output | 1 | Result is to be written |
| pair_wr_o | output | 1 | Write `result_hi_o` to `fr_addr_i` − 1 |
| skip_o | output | 1 | Skip request for conditional inc/dec |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| dcarry_o | output | 1 | Digit-carry flag |
| mulh_o | output | 8 | Multiply high byte |

## Verification
The bench builds the block with the default 9-bit address and the default list of five pair addresses. This keeps every pair slot reachable, and the random stimulus is biased so that a quarter of the file-register operations hit one of them. Directed vectors cross a 16-bit boundary in both directions (0x12FF → 0x1300, 0x0500 → 0x04FF). They also chain carry into `OP_ADDC`/`OP_SUBC` and the rotates, so the held carry path is exercised alongside the pair logic.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned OP_COUNT = 24;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_ADDC   = 5'd1,
    OP_SUB    = 5'd2,
    OP_SUBC   = 5'd3,
    OP_CMP    = 5'd4,
    OP_AND    = 5'd5,
    OP_OR     = 5'd6,
    OP_XOR    = 5'd7,
    OP_NOT    = 5'd8,
    OP_INC    = 5'd9,
    OP_DEC    = 5'd10,
    OP_INCSZ  = 5'd11,
    OP_INCSNZ = 5'd12,
    OP_DECSZ  = 5'd13,
    OP_DECSNZ = 5'd14,
    OP_TEST   = 5'd15,
    OP_CLR    = 5'd16,
    OP_MOV    = 5'd17,
    OP_MOVW   = 5'd18,
    OP_RL     = 5'd19,
    OP_RR     = 5'd20,
    OP_SWAP   = 5'd21,
    OP_MULU   = 5'd22,
    OP_MULS   = 5'd23
  } bxu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic dc;
  } bxu_flags_t;
endpackage

// File: rtl/bxu_adder.sv
module bxu_adder
  import bxu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] sum_o,
  output logic              cout_o,
  output logic              dcout_o
);
  logic [NIB_W:0] lo_sum;
  logic [NIB_W:0] hi_sum;

  always_comb begin
    lo_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    hi_sum  = {1'b0, a_i[BYTE_W-1:NIB_W]} + {1'b0, b_i[BYTE_W-1:NIB_W]} + {{NIB_W{1'b0}}, lo_sum[NIB_W]};
    sum_o   = {hi_sum[NIB_W-1:0], lo_sum[NIB_W-1:0]};
    cout_o  = hi_sum[NIB_W];
    dcout_o = lo_sum[NIB_W];
  end
endmodule

// File: rtl/bxu_pair_match.sv
module bxu_pair_match #(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned PAIR_CNT = 5,
  parameter logic [PAIR_CNT*ADDR_W-1:0] PAIR_ADDRS = {9'h011, 9'h00D, 9'h009, 9'h007, 9'h005}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [PAIR_CNT-1:0] slot_hit;

  for (genvar i = 0; i < PAIR_CNT; i++) begin : g_slot
    assign slot_hit[i] = (addr_i == PAIR_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/bxu_flag_regs.sv
module bxu_flag_regs
  import bxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              upd_z_i,
  input  logic              upd_c_i,
  input  logic              upd_dc_i,
  input  logic              upd_mulh_i,
  input  bxu_flags_t        flags_nxt_i,
  input  logic [BYTE_W-1:0] mulh_nxt_i,
  output bxu_flags_t        flags_o,
  output logic [BYTE_W-1:0] mulh_o
);
  bxu_flags_t        flags_q, flags_d;
  logic [BYTE_W-1:0] mulh_q, mulh_d;

  always_comb begin
    flags_d = flags_q;
    mulh_d  = mulh_q;
    if (wr_en_i) begin
      if (upd_z_i)    flags_d.z  = flags_nxt_i.z;
      if (upd_c_i)    flags_d.c  = flags_nxt_i.c;
      if (upd_dc_i)   flags_d.dc = flags_nxt_i.dc;
      if (upd_mulh_i) mulh_d     = mulh_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mulh_q  <= '0;
    end else begin
      flags_q <= flags_d;
      mulh_q  <= mulh_d;
    end
  end

  assign flags_o = flags_q;
  assign mulh_o  = mulh_q;

  // R11: nothing moves without the commit strobe
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(flags_q) && $stable(mulh_q)));
  // R7: the high byte only moves on a committed multiply
  assert_mulh_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && upd_mulh_i) |=> $stable(mulh_q));
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import bxu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned PAIR_CNT = 5,
  parameter logic [PAIR_CNT*ADDR_W-1:0] PAIR_ADDRS = {9'h011, 9'h00D, 9'h009, 9'h007, 9'h005}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic              lit_sel_i,
  input  logic              to_file_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] w_i,
  input  logic [ADDR_W-1:0] fr_addr_i,
  input  logic [BYTE_W-1:0] fr_i,
  input  logic [BYTE_W-1:0] fr_hi_i,
  input  logic [BYTE_W-1:0] lit_i,
  output logic [BYTE_W-1:0] result_o,
  output logic [BYTE_W-1:0] result_hi_o,
  output logic              dest_file_o,
  output logic              write_o,
  output logic              pair_wr_o,
  output logic              skip_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              dcarry_o,
  output logic [BYTE_W-1:0] mulh_o
);
  localparam int unsigned PROD_W = 2 * BYTE_W;

  bxu_op_e           op;
  bxu_flags_t        flags_q, flags_nxt;
  logic [BYTE_W-1:0] opd, add_a, add_b, add_sum, res, hi_res, mulh_nxt;
  logic              add_cin, add_cout, add_dcout;
  logic              upd_z, upd_c, upd_dc, upd_mulh;
  logic              dest_file, wr, widen_ok, hi_ext, skip_c, pair_hit, pair_act;
  logic [PROD_W-1:0] prod_u, prod_s;

  assign op  = bxu_op_e'(op_i);
  assign opd = lit_sel_i ? lit_i : fr_i;

  assign prod_u = {{BYTE_W{1'b0}}, w_i} * {{BYTE_W{1'b0}}, opd};
  assign prod_s = $signed({{BYTE_W{w_i[BYTE_W-1]}}, w_i}) * $signed({{BYTE_W{opd[BYTE_W-1]}}, opd});

  bxu_adder u_add (
    .a_i     (add_a),
    .b_i     (add_b),
    .cin_i   (add_cin),
    .sum_o   (add_sum),
    .cout_o  (add_cout),
    .dcout_o (add_dcout)
  );

  bxu_pair_match #(
    .ADDR_W     (ADDR_W),
    .PAIR_CNT   (PAIR_CNT),
    .PAIR_ADDRS (PAIR_ADDRS)
  ) u_pair (
    .addr_i (fr_addr_i),
    .hit_o  (pair_hit)
  );

  always_comb begin
    add_a     = opd;
    add_b     = '0;
    add_cin   = 1'b0;
    res       = opd;
    dest_file = to_file_i;
    wr        = 1'b1;
    upd_z     = 1'b0;
    upd_c     = 1'b0;
    upd_dc    = 1'b0;
    upd_mulh  = 1'b0;
    widen_ok  = 1'b0;
    hi_ext    = 1'b0;
    skip_c    = 1'b0;
    mulh_nxt  = '0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        add_a    = w_i;
        add_b    = opd;
        add_cin  = (op == OP_ADDC) ? flags_q.c : 1'b0;
        res      = add_sum;
        upd_z    = 1'b1;
        upd_c    = 1'b1;
        upd_dc   = 1'b1;
        widen_ok = 1'b1;
      end
      OP_SUB, OP_SUBC, OP_CMP: begin
        add_b    = ~w_i;
        add_cin  = (op == OP_SUBC) ? flags_q.c : 1'b1;
        res      = add_sum;
        upd_z    = 1'b1;
        upd_c    = 1'b1;
        upd_dc   = 1'b1;
        widen_ok = (op != OP_CMP);
        hi_ext   = 1'b1;
        wr       = (op != OP_CMP);
      end
      OP_INC, OP_INCSZ, OP_INCSNZ: begin
        add_cin  = 1'b1;
        res      = add_sum;
        upd_z    = (op == OP_INC);
        widen_ok = (op == OP_INC);
        skip_c   = (op == OP_INCSZ) ? (add_sum == '0)
                 : (op == OP_INCSNZ) ? (add_sum != '0) : 1'b0;
      end
      OP_DEC, OP_DECSZ, OP_DECSNZ: begin
        add_b    = '1;
        res      = add_sum;
        upd_z    = (op == OP_DEC);
        widen_ok = (op == OP_DEC);
        hi_ext   = 1'b1;
        skip_c   = (op == OP_DECSZ) ? (add_sum == '0)
                 : (op == OP_DECSNZ) ? (add_sum != '0) : 1'b0;
      end
      OP_AND:  begin res = w_i & opd; upd_z = 1'b1; end
      OP_OR:   begin res = w_i | opd; upd_z = 1'b1; end
      OP_XOR:  begin res = w_i ^ opd; upd_z = 1'b1; end
      OP_NOT:  begin res = ~opd;      upd_z = 1'b1; end
      OP_TEST: begin wr = 1'b0;       upd_z = 1'b1; end
      OP_CLR:  begin res = '0;        upd_z = 1'b1; end
      OP_MOV:  upd_z = !to_file_i && !lit_sel_i;
      OP_MOVW: res = w_i;
      OP_RL: begin
        res   = {opd[BYTE_W-2:0], flags_q.c};
        upd_c = 1'b1;
      end
      OP_RR: begin
        res   = {flags_q.c, opd[BYTE_W-1:1]};
        upd_c = 1'b1;
      end
      OP_SWAP: res = {opd[NIB_W-1:0], opd[BYTE_W-1:NIB_W]};
      OP_MULU, OP_MULS: begin
        res      = (op == OP_MULS) ? prod_s[BYTE_W-1:0] : prod_u[BYTE_W-1:0];
        mulh_nxt = (op == OP_MULS) ? prod_s[PROD_W-1:BYTE_W] : prod_u[PROD_W-1:BYTE_W];
        upd_mulh = 1'b1;
      end
      default: wr = 1'b0;
    endcase
    if (lit_sel_i && op != OP_MOVW) dest_file = 1'b0;
    if (op == OP_MULU || op == OP_MULS) dest_file = 1'b0;
    if (op == OP_MOVW) dest_file = 1'b1;
  end

  assign pair_act = widen_ok && pair_hit && dest_file && !lit_sel_i;
  assign hi_res   = fr_hi_i + {BYTE_W{hi_ext}} + {{(BYTE_W-1){1'b0}}, add_cout};

  always_comb begin
    flags_nxt.z  = (res == '0);
    flags_nxt.c  = (op == OP_RL) ? opd[BYTE_W-1] : (op == OP_RR) ? opd[0] : add_cout;
    flags_nxt.dc = add_dcout;
  end

  bxu_flag_regs u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .upd_z_i     (upd_z),
    .upd_c_i     (upd_c),
    .upd_dc_i    (upd_dc),
    .upd_mulh_i  (upd_mulh),
    .flags_nxt_i (flags_nxt),
    .mulh_nxt_i  (mulh_nxt),
    .flags_o     (flags_q),
    .mulh_o      (mulh_o)
  );

  assign result_o    = res;
  assign result_hi_o = pair_act ? hi_res : '0;
  assign pair_wr_o   = pair_act;
  assign dest_file_o = dest_file;
  assign write_o     = wr;
  assign skip_o      = skip_c && wr_en_i;
  assign zero_o      = flags_q.z;
  assign carry_o     = flags_q.c;
  assign dcarry_o    = flags_q.dc;

  // R8: the high byte is only ever written back to the file
  assert_pair_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_wr_o |-> (dest_file_o && write_o && !lit_sel_i));
  // R10: a committed skip operation leaves the flags alone
  assert_skip_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |=> $stable({zero_o, carry_o, dcarry_o}));
  // R5: rotate left lands the operand's top bit in carry
  assert_rl_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_RL) |=> (carry_o == $past(lit_sel_i ? lit_i[BYTE_W-1] : fr_i[BYTE_W-1])));
  // R6: nibble swap is flag-neutral
  assert_swap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_SWAP) |=> $stable({zero_o, carry_o, dcarry_o}));
  // R7: products always land in W
  assert_mul_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MULU || op_i == OP_MULS) |-> (!dest_file_o && write_o));
endmodule

// File: tb/sim_byte_exec_unit.sv
`timescale 1ns/1ps
module sim_byte_exec_unit;
  import bxu_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] op_i;
  logic lit_sel_i, to_file_i, wr_en_i;
  logic [7:0] w_i, fr_i, fr_hi_i, lit_i;
  logic [8:0] fr_addr_i;
  logic [7:0] result_o, result_hi_o, mulh_o;
  logic dest_file_o, write_o, pair_wr_o, skip_o, zero_o, carry_o, dcarry_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mz = 0, mc = 0, mdc = 0, mmulh = 0;

  always #2 clk = ~clk;

  byte_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_sel_i(lit_sel_i), .to_file_i(to_file_i),
    .wr_en_i(wr_en_i), .w_i(w_i), .fr_addr_i(fr_addr_i), .fr_i(fr_i), .fr_hi_i(fr_hi_i),
    .lit_i(lit_i), .result_o(result_o), .result_hi_o(result_hi_o), .dest_file_o(dest_file_o),
    .write_o(write_o), .pair_wr_o(pair_wr_o), .skip_o(skip_o), .zero_o(zero_o),
    .carry_o(carry_o), .dcarry_o(dcarry_o), .mulh_o(mulh_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R11 watchdog expired: actual cycles %0d expected < 100000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic string req_of(bxu_op_e op);
    case (op)
      OP_ADD, OP_ADDC:                          return "R2";
      OP_SUB, OP_SUBC, OP_CMP:                  return "R3";
      OP_RL, OP_RR:                             return "R5";
      OP_SWAP:                                  return "R6";
      OP_MULU, OP_MULS:                         return "R7";
      OP_INCSZ, OP_INCSNZ, OP_DECSZ, OP_DECSNZ: return "R10";
      default:                                  return "R4";
    endcase
  endfunction

  task automatic apply(bxu_op_e op, bit dir, bit ls, bit we, int w, int a, int f, int h, int l);
    int opd, res, dst, wr, pr, hv, sk, nz, nc, ndc, nm, cin, bin, s, v, sw, so, p;
    bit zu, in_list, wide;
    string rq;
    @(negedge clk);
    op_i = op; to_file_i = dir; lit_sel_i = ls; wr_en_i = we;
    w_i = w[7:0]; fr_addr_i = a[8:0]; fr_i = f[7:0]; fr_hi_i = h[7:0]; lit_i = l[7:0];
    #1;
    opd = ls ? l : f;
    res = 0; wr = 1; pr = 0; hv = 0; sk = 0; zu = 0;
    nz = mz; nc = mc; ndc = mdc; nm = mmulh;
    in_list = (a == 5 || a == 7 || a == 9 || a == 13 || a == 17);
    wide = !ls && dir && in_list &&
           (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_INC, OP_DEC});
    dst = dir;
    if (ls && op != OP_MOVW) dst = 0;
    case (op)
      OP_ADD, OP_ADDC: begin
        cin = (op == OP_ADDC) ? mc : 0;
        s = w + opd + cin;
        res = s & 255; nc = (s > 255); ndc = ((w % 16) + (opd % 16) + cin) > 15; zu = 1;
        if (wide) begin v = (h * 256 + f + w + cin) & 65535; res = v & 255; hv = v / 256; end
      end
      OP_SUB, OP_SUBC, OP_CMP: begin
        bin = (op == OP_SUBC) ? (mc ? 0 : 1) : 0;
        s = opd - w - bin;
        res = s & 255; nc = (s >= 0); ndc = ((opd % 16) - (w % 16) - bin) >= 0; zu = 1;
        if (op == OP_CMP) wr = 0;
        if (wide) begin v = (h * 256 + f - w - bin) & 65535; res = v & 255; hv = v / 256; end
      end
      OP_INC: begin res = (opd + 1) & 255; zu = 1;
        if (wide) begin v = (h * 256 + f + 1) & 65535; res = v & 255; hv = v / 256; end end
      OP_DEC: begin res = (opd + 255) & 255; zu = 1;
        if (wide) begin v = (h * 256 + f + 65535) & 65535; res = v & 255; hv = v / 256; end end
      OP_INCSZ:  begin res = (opd + 1) & 255;   sk = (res == 0); end
      OP_INCSNZ: begin res = (opd + 1) & 255;   sk = (res != 0); end
      OP_DECSZ:  begin res = (opd + 255) & 255; sk = (res == 0); end
      OP_DECSNZ: begin res = (opd + 255) & 255; sk = (res != 0); end
      OP_AND:  begin res = w & opd; zu = 1; end
      OP_OR:   begin res = w | opd; zu = 1; end
      OP_XOR:  begin res = w ^ opd; zu = 1; end
      OP_NOT:  begin res = 255 - opd; zu = 1; end
      OP_TEST: begin res = opd; wr = 0; zu = 1; end
      OP_CLR:  begin res = 0; zu = 1; end
      OP_MOV:  begin res = opd; zu = (!dir && !ls); end
      OP_MOVW: begin res = w; dst = 1; end
      OP_RL:   begin res = ((opd * 2) & 255) + mc; nc = opd / 128; end
      OP_RR:   begin res = opd / 2 + mc * 128; nc = opd % 2; end
      OP_SWAP: res = (opd % 16) * 16 + opd / 16;
      default: begin // multiplies
        if (op == OP_MULS) begin
          sw = (w > 127) ? w - 256 : w; so = (opd > 127) ? opd - 256 : opd;
        end else begin sw = w; so = opd; end
        p = (sw * so) & 65535; res = p & 255; nm = p / 256; dst = 0;
      end
    endcase
    if (zu) nz = (res == 0);
    pr = wide;
    sk = sk && we;
    rq = req_of(op);
    chk("R1", "write_o", write_o, wr);
    if (wr) begin
      chk(wide ? "R8" : rq, "result_o", result_o, res);
      chk("R1", "dest_file_o", dest_file_o, dst);
    end
    chk("R8", "pair_wr_o", pair_wr_o, pr);
    if (pr) chk("R8", "result_hi_o", result_hi_o, hv);
    chk("R10", "skip_o", skip_o, sk);
    @(posedge clk); #1;
    if (we) begin mz = nz; mc = nc; mdc = ndc; mmulh = nm; end
    rq = !we ? "R11" : wide ? "R9" : rq;
    chk(rq, "zero_o", zero_o, mz);
    chk(rq, "carry_o", carry_o, mc);
    chk(rq, "dcarry_o", dcarry_o, mdc);
    chk((op == OP_MULU || op == OP_MULS) ? "R7" : "R11", "mulh_o", mulh_o, mmulh);
  endtask

  initial begin
    rst_n = 1'b0;
    op_i = '0; lit_sel_i = 0; to_file_i = 0; wr_en_i = 0;
    w_i = '0; fr_addr_i = '0; fr_i = '0; fr_hi_i = '0; lit_i = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset zero_o", zero_o, 0);
    chk("R11", "reset carry_o", carry_o, 0);
    chk("R11", "reset dcarry_o", dcarry_o, 0);
    chk("R11", "reset mulh_o", mulh_o, 0);
    rst_n = 1'b1;

    // R2: nibble carry and 8-bit overflow
    apply(OP_ADD,  0, 0, 1, 8'h0F, 9'h020, 8'h01, 0, 0);
    apply(OP_ADD,  1, 0, 1, 8'hF0, 9'h020, 8'h10, 0, 0);
    apply(OP_ADDC, 0, 1, 1, 8'h01, 9'h000, 0, 0, 8'h01);
    // R3: borrow, borrow-in, compare, literal subtract
    apply(OP_SUB,  0, 0, 1, 8'h05, 9'h030, 8'h03, 0, 0);
    apply(OP_SUBC, 0, 0, 1, 8'h01, 9'h030, 8'h05, 0, 0);
    apply(OP_CMP,  0, 0, 1, 8'h42, 9'h030, 8'h42, 0, 0);
    apply(OP_SUB,  0, 1, 1, 8'h10, 9'h000, 0, 0, 8'h30);
    // R5: rotates through carry
    apply(OP_RL,   1, 0, 1, 0, 9'h040, 8'h81, 0, 0);
    apply(OP_RR,   0, 0, 1, 0, 9'h040, 8'h02, 0, 0);
    // R6, R4
    apply(OP_SWAP, 1, 0, 1, 0, 9'h041, 8'hA5, 0, 0);
    apply(OP_MOVW, 0, 0, 1, 8'h00, 9'h041, 8'h77, 0, 0);
    apply(OP_MOV,  0, 0, 1, 8'h33, 9'h041, 8'h00, 0, 0);
    apply(OP_CLR,  1, 0, 1, 0, 9'h041, 8'h12, 0, 0);
    // R7: signed and unsigned products
    apply(OP_MULU, 1, 0, 1, 8'hFF, 9'h050, 8'hFF, 0, 0);
    apply(OP_MULS, 0, 1, 1, 8'hFF, 9'h000, 0, 0, 8'hFF);
    apply(OP_MULS, 0, 0, 1, 8'h80, 9'h050, 8'h7F, 0, 0);
    // R8, R9: pair widening across byte boundaries
    apply(OP_INC,  1, 0, 1, 0, 9'h009, 8'hFF, 8'h12, 0);
    apply(OP_DEC,  1, 0, 1, 0, 9'h011, 8'h00, 8'h05, 0);
    apply(OP_ADD,  1, 0, 1, 8'h80, 9'h005, 8'h90, 8'hFF, 0);
    apply(OP_SUBC, 1, 0, 1, 8'h01, 9'h00D, 8'h00, 8'h00, 0);
    apply(OP_INC,  0, 0, 1, 0, 9'h007, 8'hFF, 8'h12, 0);
    apply(OP_INC,  1, 0, 1, 0, 9'h008, 8'hFF, 8'h12, 0);
    // R10: skip requests
    apply(OP_INCSZ,  1, 0, 1, 0, 9'h060, 8'hFF, 0, 0);
    apply(OP_DECSNZ, 0, 0, 1, 0, 9'h060, 8'h01, 0, 0);
    apply(OP_DECSZ,  1, 0, 0, 0, 9'h060, 8'h01, 0, 0);
    // R11: no commit, no change
    apply(OP_ADD,  0, 0, 0, 8'hFF, 9'h020, 8'hFF, 0, 0);
    apply(OP_MULU, 0, 0, 0, 8'h10, 9'h020, 8'h10, 0, 0);

    for (int i = 0; i < 1500; i++) begin
      int r, a;
      r = $urandom;
      a = (r % 4 == 0) ? ((r / 4) % 5 == 0 ? 5 : (r / 4) % 5 == 1 ? 7 : (r / 4) % 5 == 2 ? 9 :
                          (r / 4) % 5 == 3 ? 13 : 17)
                       : ($urandom % 512);
      apply(bxu_op_e'($urandom % OP_COUNT), 1'($urandom % 2), 1'($urandom % 4 == 0),
            1'($urandom % 8 != 0), $urandom % 256, a, $urandom % 256, $urandom % 256,
            $urandom % 256);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule